// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Table

This block keeps atomic-access reservations for a shared memory controller. It has a fixed number of slots. Each slot holds an address and a key. The slot count is a parameter and does not depend on how many processors share the memory. Requests arrive one at a time on a single valid/ready port, and each result is registered.

A load-linked (LL) records the address and returns a key. The requesting processor keeps that key and presents it with its later store-conditional (SC). The SC succeeds only if the table still holds a live reservation with the same address and the same key. A successful SC consumes that reservation.

Plain writes and successful compare-and-swaps remove any reservation on their address. Keys are values of a wrapping counter of accepted LL requests. A reservation dies once `LIFE` further LL requests have been accepted. This bound means no processor identity has to be stored.

Back-pressure works as follows:
- `req_ready` is high whenever the result register is empty, or is being emptied in the same cycle.
- A result stays on the outputs, unchanged, until it is taken with `rsp_ready`.

Top module: `llsc_resv_table`

## Requirements
- R1: The 3-bit `req_kind` carries the low bits of the request type: 3'b110 is LL, 3'b111 is SC, 3'b100 is a plain write, and 3'b101 is a successful compare-and-swap. An LL to an address with no live reservation returns `rsp_ok`=1 and a key equal to the number of LL requests accepted since reset before it, modulo 2^KEY_W.
- R2: An LL to an address that already holds a live reservation returns that reservation's existing key and allocates no slot. It still advances the LL count.
- R3: An SC returns `rsp_ok`=1 only when a live reservation matches both its address and its key. A successful SC consumes the reservation, so a repeat SC fails. SC responses carry key 0.
- R4: A failing SC leaves every reservation unchanged.
- R5: A plain write (3'b100) or a successful compare-and-swap (3'b101) removes the reservation on its address and answers `rsp_ok`=1 with key 0. Reservations on other addresses are untouched.
- R6: Any other kind code (3'b000 to 3'b011) changes nothing and answers `rsp_ok`=0 with key 0.
- R7: A reservation created by an LL stays live while fewer than `LIFE` later LL requests have been accepted. Once the `LIFE`-th later LL is accepted, the reservation is dead.
- R8: An LL miss takes a free slot, the lowest-numbered one first. When no slot is free, it replaces the reservation that has seen the most LL requests since it was created.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. The result of an accepted request appears on the next cycle. While `rsp_ready` is low, that result holds steady.
- R10: After reset, `rsp_valid` is 0, the table is empty and the LL count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_kind | input | 3 | Request type code |
| req_addr | input | ADDR_W | Reserved or written address |
| req_key | input | KEY_W | Key presented by an SC |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken this cycle when high |
| rsp_key | output | KEY_W | Key returned by an LL, otherwise 0 |
| rsp_ok | output | 1 | LL done, SC success, or kill done |

## Verification
Any corruption of a slot's address, key or valid bit becomes visible at the ports on the next SC or LL to that address. A lost slot shows up as an SC that fails when it should succeed, or as an LL that returns a fresh key instead of the old one. A wrong LL count shows up in the very next LL key. A bad expiry or eviction choice shows up only after the next SC to the affected address, which can be many requests later. For that reason the bench checks every request of a long mixed stream against a model, through counter wraparound.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  localparam logic [2:0] KIND_LL  = 3'b110;
  localparam logic [2:0] KIND_SC  = 3'b111;
  localparam logic [2:0] KIND_WR  = 3'b100;
  localparam logic [2:0] KIND_CAS = 3'b101;
endpackage

// File: rtl/llsc_slot_cmp.sv
module llsc_slot_cmp #(
  parameter int SLOTS  = 32,
  parameter int ADDR_W = 32,
  parameter int KEY_W  = 14
) (
  input  logic [SLOTS-1:0]             slot_vld,
  input  logic [SLOTS-1:0][ADDR_W-1:0] slot_addr,
  input  logic [SLOTS-1:0][KEY_W-1:0]  slot_key,
  input  logic [ADDR_W-1:0]            cmp_addr,
  input  logic [KEY_W-1:0]             cmp_key,
  input  logic [KEY_W-1:0]             ctr_next,
  output logic [SLOTS-1:0]             addr_hit,
  output logic [SLOTS-1:0]             key_hit,
  output logic [SLOTS-1:0][KEY_W-1:0]  age
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign addr_hit[i] = slot_vld[i] && (slot_addr[i] == cmp_addr);
    assign key_hit[i]  = slot_key[i] == cmp_key;
    assign age[i]      = ctr_next - slot_key[i];
  end
endmodule

// File: rtl/llsc_victim.sv
module llsc_victim #(
  parameter int SLOTS = 32,
  parameter int KEY_W = 14,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]            avail,
  input  logic [SLOTS-1:0][KEY_W-1:0] age,
  output logic [IDX_W-1:0]            vict_idx
);
  always_comb begin
    logic             found;
    logic [KEY_W-1:0] best;
    found    = 1'b0;
    vict_idx = '0;
    best     = age[0];
    for (int i = 0; i < SLOTS; i++) begin
      if (avail[i] && !found) begin
        found    = 1'b1;
        vict_idx = IDX_W'(i);
      end
    end
    if (!found) begin
      for (int i = 1; i < SLOTS; i++) begin
        if (age[i] > best) begin
          best     = age[i];
          vict_idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int SLOTS  = 32,
  parameter int ADDR_W = 32,
  parameter int LIFE   = 8000,
  localparam int KEY_W = $clog2(LIFE + 1) + 1,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [KEY_W-1:0]  req_key,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [KEY_W-1:0]  rsp_key,
  output logic              rsp_ok
);
  import llsc_pkg::*;

  localparam logic [KEY_W-1:0] LIFE_K = KEY_W'(LIFE);

  logic [SLOTS-1:0]             slot_vld;
  logic [SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [SLOTS-1:0][KEY_W-1:0]  slot_key;
  logic [KEY_W-1:0]             ll_ctr;
  logic [KEY_W-1:0]             ctr_next;
  logic [SLOTS-1:0]             addr_hit;
  logic [SLOTS-1:0]             key_hit;
  logic [SLOTS-1:0][KEY_W-1:0]  age;
  logic [SLOTS-1:0]             expire;
  logic [SLOTS-1:0]             live_hit;
  logic [SLOTS-1:0]             sc_hit;
  logic [KEY_W-1:0]             hit_key;
  logic [IDX_W-1:0]             vict_idx;
  logic                         accept;

  assign ctr_next  = ll_ctr + 1'b1;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  llsc_slot_cmp #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_cmp (
    .slot_vld (slot_vld),
    .slot_addr(slot_addr),
    .slot_key (slot_key),
    .cmp_addr (req_addr),
    .cmp_key  (req_key),
    .ctr_next (ctr_next),
    .addr_hit (addr_hit),
    .key_hit  (key_hit),
    .age      (age)
  );

  // Ages move up by one per LL, so sweeping at every LL keeps them below wrap.
  for (genvar i = 0; i < SLOTS; i++) begin : g_exp
    assign expire[i] = slot_vld[i] && (age[i] > LIFE_K);
  end

  assign live_hit = addr_hit & ~expire;
  assign sc_hit   = addr_hit & key_hit;

  always_comb begin
    hit_key = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (live_hit[i]) hit_key = hit_key | slot_key[i];
    end
  end

  llsc_victim #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_victim (
    .avail   (~slot_vld | expire),
    .age     (age),
    .vict_idx(vict_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vld  <= '0;
      slot_addr <= '0;
      slot_key  <= '0;
      ll_ctr    <= '0;
      rsp_valid <= 1'b0;
      rsp_key   <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_key   <= '0;
        rsp_ok    <= 1'b0;
        unique case (req_kind)
          KIND_LL: begin
            ll_ctr   <= ctr_next;
            rsp_ok   <= 1'b1;
            slot_vld <= slot_vld & ~expire;
            if (|live_hit) begin
              rsp_key <= hit_key;
            end else begin
              rsp_key             <= ll_ctr;
              slot_vld[vict_idx]  <= 1'b1;
              slot_addr[vict_idx] <= req_addr;
              slot_key[vict_idx]  <= ll_ctr;
            end
          end
          KIND_SC: begin
            rsp_ok   <= |sc_hit;
            slot_vld <= slot_vld & ~sc_hit;
          end
          KIND_WR, KIND_CAS: begin
            rsp_ok   <= 1'b1;
            slot_vld <= slot_vld & ~addr_hit;
          end
          default: ;
        endcase
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/llsc_resv_table_chk.sv
module llsc_resv_table_chk #(
  parameter int SLOTS = 32,
  parameter int KEY_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_kind,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [KEY_W-1:0] rsp_key,
  input logic             rsp_ok,
  input logic [SLOTS-1:0] addr_hit
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_key) && $stable(rsp_ok)));

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_rsp_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_ll_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 3'b110) |=> rsp_ok);

  assert_other_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind[2] == 1'b0) |=> (!rsp_ok && rsp_key == '0));

  // R2: a single live slot per address
  assert_unique_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_hit));
endmodule

bind llsc_resv_table llsc_resv_table_chk #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_kind (req_kind),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_key  (rsp_key),
  .rsp_ok   (rsp_ok),
  .addr_hit (addr_hit)
);

// File: tb/llsc_resv_table_bench.sv
module llsc_resv_table_bench;
  localparam int NS = 4;
  localparam int AW = 8;
  localparam int LF = 6;
  localparam int KW = $clog2(LF + 1) + 1;
  localparam int MODK = 1 << KW;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [2:0] req_kind = 0;
  logic [AW-1:0] req_addr = 0;
  logic [KW-1:0] req_key = 0;
  logic rsp_valid;
  logic rsp_ready = 1;
  logic [KW-1:0] rsp_key;
  logic rsp_ok;

  int n_chk = 0;
  int n_bad = 0;

  bit m_vld[NS];
  int m_addr[NS];
  int m_key[NS];
  int m_ctr = 0;

  always #4 clk = ~clk;

  llsc_resv_table #(.SLOTS(NS), .ADDR_W(AW), .LIFE(LF)) u_llsc_resv_table (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_key(req_key),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_key(rsp_key), .rsp_ok(rsp_ok)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int kind, input int a, input int k, output int ok, output int key);
    ok = 0;
    key = 0;
    if (kind == 6) begin
      int nxt, hit, v, best;
      nxt = (m_ctr + 1) % MODK;
      for (int i = 0; i < NS; i++)
        if (m_vld[i] && ((nxt - m_key[i] + MODK) % MODK) > LF) m_vld[i] = 0;
      hit = -1;
      for (int i = 0; i < NS; i++) if (m_vld[i] && m_addr[i] == a) hit = i;
      ok = 1;
      if (hit >= 0) key = m_key[hit];
      else begin
        v = -1;
        for (int i = NS - 1; i >= 0; i--) if (!m_vld[i]) v = i;
        if (v < 0) begin
          v = 0;
          best = (nxt - m_key[0] + MODK) % MODK;
          for (int i = 1; i < NS; i++)
            if (((nxt - m_key[i] + MODK) % MODK) > best) begin
              best = (nxt - m_key[i] + MODK) % MODK;
              v = i;
            end
        end
        m_vld[v] = 1;
        m_addr[v] = a;
        m_key[v] = m_ctr;
        key = m_ctr;
      end
      m_ctr = nxt;
    end else if (kind == 7) begin
      for (int i = 0; i < NS; i++)
        if (m_vld[i] && m_addr[i] == a && m_key[i] == k) begin
          m_vld[i] = 0;
          ok = 1;
        end
    end else if (kind == 4 || kind == 5) begin
      ok = 1;
      for (int i = 0; i < NS; i++) if (m_vld[i] && m_addr[i] == a) m_vld[i] = 0;
    end
  endtask

  task automatic do_op(input string req, input int kind, input int a, input int k,
                       output int got_key);
    int eok, ekey;
    model(kind, a, k, eok, ekey);
    @(negedge clk);
    req_valid = 1;
    req_kind = 3'(kind);
    req_addr = AW'(a);
    req_key = KW'(k);
    @(negedge clk);
    req_valid = 0;
    check({req, " rsp_valid"}, int'(rsp_valid), 1);
    check({req, " ok"}, int'(rsp_ok), eok);
    check({req, " key"}, int'(rsp_key), ekey);
    got_key = int'(rsp_key);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int kk, k0, lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 rsp_valid after reset", int'(rsp_valid), 0);
    check("R9 req_ready after reset", int'(req_ready), 1);

    do_op("R1 first LL", 6, 10, 0, kk);
    check("R1 first key literal", kk, 0);
    do_op("R2 repeat LL", 6, 10, 0, kk);
    check("R2 same key literal", kk, 0);
    do_op("R1 LL new addr", 6, 20, 0, kk);
    check("R1 key counts LLs", kk, 2);
    do_op("R4 SC wrong key", 7, 10, 1, kk);
    do_op("R3 SC wrong addr", 7, 30, 0, kk);
    do_op("R3 SC match", 7, 10, 0, kk);
    do_op("R3 SC consumed", 7, 10, 0, kk);
    do_op("R6 read kind", 0, 20, 0, kk);
    do_op("R6 kind 3", 3, 20, 2, kk);
    do_op("R6 SC after ignored kinds", 7, 20, 2, kk);

    do_op("R5 LL", 6, 11, 0, k0);
    do_op("R5 write", 4, 11, 0, kk);
    do_op("R5 SC after write", 7, 11, k0, kk);
    do_op("R5 LL", 6, 12, 0, k0);
    do_op("R5 CAS", 5, 12, 0, kk);
    do_op("R5 SC after CAS", 7, 12, k0, kk);
    do_op("R5 LL", 6, 13, 0, k0);
    do_op("R5 write other", 4, 14, 0, kk);
    do_op("R5 SC untouched", 7, 13, k0, kk);

    // R7: five later LLs keep it, six kill it
    do_op("R7 LL X", 6, 60, 0, k0);
    do_op("R7 LL Y", 6, 61, 0, kk);
    for (int i = 0; i < 4; i++) do_op("R7 LL Y hit", 6, 61, 0, kk);
    do_op("R7 SC X live", 7, 60, k0, kk);
    check("R7 SC X live literal", int'(rsp_ok), 1);
    do_op("R7 LL X", 6, 60, 0, k0);
    do_op("R7 LL Z", 6, 62, 0, kk);
    for (int i = 0; i < 5; i++) do_op("R7 LL Z hit", 6, 62, 0, kk);
    do_op("R7 SC X expired", 7, 60, k0, kk);
    check("R7 SC X expired literal", int'(rsp_ok), 0);

    // R8: fill then evict the oldest
    for (int i = 0; i < NS; i++) do_op("R8 fill", 6, 70 + i, 0, kk);
    do_op("R8 evicting LL", 6, 90, 0, kk);
    for (int i = 0; i < NS; i++) do_op("R8 SC after evict", 7, 70 + i, (m_ctr - 1 - NS + i + MODK) % MODK, kk);

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1;
    req_kind = 3'b110;
    req_addr = 8'd99;
    model(6, 99, 0, kk, k0);
    @(negedge clk);
    req_valid = 0;
    check("R9 rsp_valid stall", int'(rsp_valid), 1);
    check("R9 req_ready low", int'(req_ready), 0);
    check("R9 key", int'(rsp_key), k0);
    repeat (2) @(negedge clk);
    check("R9 held valid", int'(rsp_valid), 1);
    check("R9 held key", int'(rsp_key), k0);
    rsp_ready = 1;
    @(negedge clk);
    check("R9 drained", int'(rsp_valid), 0);

    // mixed stream through key wraparound
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      int sel, a, k;
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      sel = lfsr % 8;
      a = (lfsr >> 3) % 6;
      k = (lfsr >> 6) % MODK;
      if (sel < 4) do_op("R8 stream LL", 6, a, 0, kk);
      else if (sel < 6) begin
        int mk;
        mk = k;
        for (int j = 0; j < NS; j++) if (m_vld[j] && m_addr[j] == a && sel == 4) mk = m_key[j];
        do_op("R3 stream SC", 7, a, mk, kk);
      end else if (sel == 6) do_op("R5 stream write", 4, a, 0, kk);
      else do_op("R6 stream other", 1, a, 0, kk);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule